// File: doc/BRIEF.md
# Reset-Windowed Nonvolatile Region Protect Register

This block holds one protect bit for each protectable part of an on-chip nonvolatile store: bit 0 guards the single configuration location, and bits 1 and up each guard one equal-sized area of the array. After reset every bit is set, so programming and erasing are blocked until software deliberately unlocks a region. Unlocking is allowed only during a short window of clock cycles right after reset. Once that window has closed, software can only add protection, never remove it. A bit that software sets again after having cleared it stays set until the next reset, even when the window is still open.

The program interlock hands the block the address of the pending program or erase. One cycle later the block returns a one-hot region select and an inhibit flag. The interlock uses that flag to suppress both the array write and the high-voltage enable for a protected address. The region map is a parameterized comparator: a fixed configuration address and a run of consecutive array areas, each `REGION_SIZE` bytes long, starting at `ARRAY_BASE`.

Top module: `region_guard`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the block comes out of that edge with every bit of `lock` at 1, `window_open` at 1, and `chk_sel` and `chk_block` at 0.
- R2: `window_open` stays 1 across exactly `WINDOW_CYCLES` (default 64) rising edges after the last reset edge. It then reads 0 and stays 0 until the next reset.
- R3: A write (`wr_en`=1) made while `window_open` is 1 clears each `lock` bit whose `wr_data` bit is 0, provided that bit has not been resealed since reset.
- R4: A write made while `window_open` is 0 never clears any `lock` bit.
- R5: A write sets each `lock` bit whose `wr_data` bit is 1, at any time.
- R6: A bit that is written to 1 while it reads 0 is resealed. Later zero writes leave it at 1 until the next reset, even inside the window.
- R7: The bits act independently. Bit 0 covers the address `CFG_ADDR`. Bit i (i ≥ 1) covers `ARRAY_BASE + (i-1)*REGION_SIZE` up to, but not including, `ARRAY_BASE + i*REGION_SIZE`.
- R8: One edge after `chk_addr` is sampled, `chk_sel` shows the one-hot region for that address as mapped in R7, or all zeros for an address outside every region.
- R9: `chk_block` is 1 one edge after `chk_addr` is sampled if, and only if, the region that address selects was locked at that same edge (before any write at that edge takes effect).
- R10: A later reset re-arms the block: all bits are set again, seals are forgotten, and the window reopens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | N | Write data, one bit per region (1 = protect) |
| chk_addr | input | ADDR_W | Address of the pending program or erase |
| lock | output | N | Current protect bits |
| window_open | output | 1 | High while clearing is still allowed |
| chk_sel | output | N | Registered one-hot region of `chk_addr` |
| chk_block | output | 1 | Registered inhibit for `chk_addr` |

## Verification
Several properties are checked on every cycle:
- the reset values;
- that the window flag never reopens, and that it matches a cycle count kept apart from the design;
- that no bit drops after the window closes;
- that written ones always land;
- that the region select is at most one-hot;
- that the inhibit agrees with the select and the previous lock state.

Some behaviours only the bench scenarios can show: resealing (a bit that ignores zeros while the window is still open), the exact boundary addresses of each region, and the re-arming that a second reset brings. The bench compares these against its cycle model.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  // Index of the protect bit that guards the configuration location.
  localparam int CFG_BIT = 0;

  // Half-open span test on widened addresses, so that the upper bound cannot wrap.
  function automatic logic in_span(input logic [32:0] a,
                                   input logic [32:0] lo,
                                   input logic [32:0] size);
    return (a >= lo) && (a < lo + size);
  endfunction

endpackage

// File: rtl/region_guard_window.sv
module region_guard_window #(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic open
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      open <= 1'b1;
    end else if (open) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) open <= 1'b0;
    end
  end
endmodule

// File: rtl/region_guard_bits.sv
module region_guard_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         window_open,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] lock
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    logic sealed_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q    <= 1'b1;
        sealed_q <= 1'b0;
      end else if (wr_en) begin
        if (wr_data[i]) begin
          bit_q <= 1'b1;
          if (!bit_q) sealed_q <= 1'b1;
        end else if (window_open && !sealed_q) begin
          bit_q <= 1'b0;
        end
      end
    end

    assign lock[i] = bit_q;
  end
endmodule

// File: rtl/region_guard_decode.sv
module region_guard_decode
  import region_guard_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                N           = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 16'h103F,
  parameter logic [ADDR_W-1:0] ARRAY_BASE  = 16'hB600,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 16'h0080
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      sel
);
  localparam logic [32:0] BASE_W = 33'(ARRAY_BASE);
  localparam logic [32:0] SIZE_W = 33'(REGION_SIZE);

  logic [32:0] addr_w;
  assign addr_w = 33'(addr);

  assign sel[CFG_BIT] = (addr == CFG_ADDR);

  for (genvar i = 1; i < N; i++) begin : g_area
    localparam logic [32:0] LO = BASE_W + 33'(i - 1) * SIZE_W;
    assign sel[i] = in_span(addr_w, LO, SIZE_W);
  end
endmodule

// File: rtl/region_guard.sv
module region_guard #(
  parameter int                ADDR_W        = 16,
  parameter int                N             = 4,
  parameter int                WINDOW_CYCLES = 64,
  parameter logic [ADDR_W-1:0] CFG_ADDR      = 16'h103F,
  parameter logic [ADDR_W-1:0] ARRAY_BASE    = 16'hB600,
  parameter logic [ADDR_W-1:0] REGION_SIZE   = 16'h0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_data,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [N-1:0]      lock,
  output logic              window_open,
  output logic [N-1:0]      chk_sel,
  output logic              chk_block
);
  logic [N-1:0] sel_c;

  region_guard_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
    .clk  (clk),
    .rst  (rst),
    .open (window_open)
  );

  region_guard_bits #(.N(N)) u_bits (
    .clk         (clk),
    .rst         (rst),
    .window_open (window_open),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .lock        (lock)
  );

  region_guard_decode #(
    .ADDR_W      (ADDR_W),
    .N           (N),
    .CFG_ADDR    (CFG_ADDR),
    .ARRAY_BASE  (ARRAY_BASE),
    .REGION_SIZE (REGION_SIZE)
  ) u_decode (
    .addr (chk_addr),
    .sel  (sel_c)
  );

  // Registered check path: the inhibit uses the lock state from before this edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_sel   <= '0;
      chk_block <= 1'b0;
    end else begin
      chk_sel   <= sel_c;
      chk_block <= |(sel_c & lock);
    end
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int N             = 4,
  parameter int WINDOW_CYCLES = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [N-1:0] wr_data,
  input logic [N-1:0] lock,
  input logic         window_open,
  input logic [N-1:0] chk_sel,
  input logic         chk_block
);
  logic past_valid = 1'b0;
  int   edges      = 0;

  always_ff @(posedge clk) begin
    past_valid <= 1'b1;
    if (rst) edges <= 0;
    else if (edges < WINDOW_CYCLES) edges <= edges + 1;
  end

  // R1 / R10: reset values
  assert_reset_state_R1: assert property (@(posedge clk)
    past_valid && $past(rst) |-> (lock == '1) && window_open && (chk_sel == '0) && !chk_block);

  // R2: the flag follows an independent count of edges and never reopens
  assert_window_len_R2: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> window_open == (edges < WINDOW_CYCLES));
  assert_window_stays_shut_R2: assert property (@(posedge clk) disable iff (rst)
    !window_open |=> !window_open);

  // R4: no bit drops once the window is shut
  assert_no_late_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !window_open |=> ((lock & $past(lock)) == $past(lock)));

  // R5: written ones always land
  assert_set_lands_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((lock & $past(wr_data)) == $past(wr_data)));

  // R8: at most one region selected
  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_sel));

  // R9: inhibit agrees with the select and the lock state one edge earlier
  assert_block_match_R9: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> chk_block == |(chk_sel & $past(lock)));
endmodule

bind region_guard region_guard_chk #(.N(N), .WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .lock        (lock),
  .window_open (window_open),
  .chk_sel     (chk_sel),
  .chk_block   (chk_block)
);

// File: tb/region_guard_bench.sv
module region_guard_bench;
  localparam int N   = 4;
  localparam int AW  = 16;
  localparam int WIN = 64;
  localparam int CFG = 'h103F;
  localparam int BASE = 'hB600;
  localparam int SZ  = 'h80;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [N-1:0]  wr_data = '0;
  logic [AW-1:0] chk_addr = '0;
  logic [N-1:0]  lock;
  logic          window_open;
  logic [N-1:0]  chk_sel;
  logic          chk_block;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  region_guard u_region_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .chk_addr(chk_addr),
    .lock(lock), .window_open(window_open), .chk_sel(chk_sel), .chk_block(chk_block)
  );

  // Behavioural reference model
  int m_lock[N];
  int m_seal[N];
  int m_edges = 0;
  int m_sel = 0;
  int m_blk = 0;

  function automatic int region_of(int a);
    if (a == CFG) return 0;
    if (a >= BASE && a < BASE + (N - 1) * SZ) return 1 + (a - BASE) / SZ;
    return -1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      foreach (m_lock[i]) begin m_lock[i] = 1; m_seal[i] = 0; end
      m_edges = 0; m_sel = 0; m_blk = 0;
    end else begin
      automatic int r = region_of(int'(chk_addr));
      m_sel = (r < 0) ? 0 : (1 << r);
      m_blk = (r < 0) ? 0 : m_lock[r];
      if (wr_en) begin
        for (int i = 0; i < N; i++) begin
          if (wr_data[i]) begin
            if (m_lock[i] == 0) m_seal[i] = 1;
            m_lock[i] = 1;
          end else if (m_edges < WIN && m_seal[i] == 0) begin
            m_lock[i] = 0;
          end
        end
      end
      if (m_edges < WIN) m_edges++;
    end
  end

  function automatic logic [N-1:0] m_lock_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (m_lock[i] != 0);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 R4 R5 R6 lock", 32'(lock), 32'(m_lock_vec()));
      check("R2 window_open", 32'(window_open), 32'(m_edges < WIN));
      check("R8 chk_sel", 32'(chk_sel), 32'(m_sel));
      check("R9 chk_block", 32'(chk_block), 32'(m_blk));
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [N-1:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic probe(input int a, input logic [N-1:0] es, input logic eb, input string req);
    chk_addr = AW'(a); tick();
    check(req, 32'(chk_sel), 32'(es));
    check(req, 32'(chk_block), 32'(eb));
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    check("R1 lock", 32'(lock), 32'hF);
    check("R1 window_open", 32'(window_open), 32'd1);
    check("R1 chk_sel", 32'(chk_sel), 32'd0);
    check("R1 chk_block", 32'(chk_block), 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R3: clear bits 1 and 3 inside the window
    wr(4'b0101);
    check("R3 early clear", 32'(lock), 32'h5);
    // R7 / R8 / R9: region boundaries
    probe(BASE, 4'b0010, 1'b0, "R7 R8 R9 region1 low edge");
    probe(BASE + SZ - 1, 4'b0010, 1'b0, "R7 region1 high edge");
    probe(BASE + SZ, 4'b0100, 1'b1, "R7 R9 region2 locked");
    probe(BASE + 3 * SZ - 1, 4'b1000, 1'b0, "R7 region3 high edge");
    probe(BASE + 3 * SZ, 4'b0000, 1'b0, "R8 past array");
    probe(CFG, 4'b0001, 1'b1, "R7 R9 config locked");
    probe(0, 4'b0000, 1'b0, "R8 outside");
    // R6: reseal bit 3, then a zero write inside the window leaves it set
    wr(4'b1101);
    check("R6 reseal set", 32'(lock), 32'hD);
    wr(4'b0000);
    check("R6 sealed bit holds", 32'(lock), 32'h8);
    // R9: inhibit sampled at the same edge as a write uses the old lock
    chk_addr = AW'(CFG); wr_en = 1'b1; wr_data = 4'b1001; tick(); wr_en = 1'b0;
    check("R9 old lock used", 32'(chk_block), 32'd0);
    check("R5 set in window", 32'(lock), 32'h9);
    // R2: window closes after exactly WIN edges
    while (m_edges < WIN - 1) tick();
    check("R2 still open", 32'(window_open), 32'd1);
    tick();
    check("R2 closed", 32'(window_open), 32'd0);
    // R4: zeros ignored after the window
    wr(4'b0000);
    check("R4 late clear ignored", 32'(lock), 32'h9);
    // R5: ones still land
    wr(4'b0010);
    check("R5 late set", 32'(lock), 32'hB);
    probe(BASE, 4'b0010, 1'b1, "R9 region1 now locked");
    repeat (80) tick();
    check("R2 stays closed", 32'(window_open), 32'd0);
    // R10: second reset re-arms and forgets seals
    do_reset();
    wr(4'b0000);
    check("R10 clear after rearm", 32'(lock), 32'h0);
    probe(BASE + 2 * SZ, 4'b1000, 1'b0, "R10 region3 open");
    tick();
    finish_run();
  end
endmodule